// File: doc/BRIEF.md
# Saturating Wide Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point filter inner loop. Each cycle it can take one pair of signed 32-bit operands, form their full 64-bit product, and add that product into an 80-bit accumulator in the same step. The accumulator has 16 guard bits above the 64-bit product, so a long sum keeps its full precision even when partial sums pass well beyond the 32-bit range.

The running sum leaves the block on a registered 32-bit result, and a mode input chooses how it is narrowed. In saturating mode, a sum that does not fit is clamped to the largest positive or the most negative 32-bit value. In wrap mode, only the low 32 bits are kept. A sticky flag records every clamp until the next clear.

A clear control starts a new sum. The multiplier has two register stages. The caller must therefore allow for a fixed latency between issuing an operand pair and seeing its effect on the result.

Top module: `sat_mac`

## Requirements
- R1: While reset is asserted, and after it is released, the result reads 0 and the overflow flag reads 0 until a sampled operation reaches the accumulator.
- R2: When clear is low, accumulate-enable is high and valid is high, the full signed 64-bit product of the two two's-complement operands is sign-extended and added into the 80-bit accumulator.
- R3: When clear is low and either valid or accumulate-enable is low, the accumulator keeps its value.
- R4: When clear is high, the accumulator is loaded with the product if valid is high, or with zero if valid is low, and the overflow flag is cleared unless the same operation clamps.
- R5: With the saturate input at 1, an accumulator value above 2^31-1 reads as 0x7FFFFFFF, a value below -2^31 reads as 0x80000000, and a value in range reads exactly.
- R6: With the saturate input at 0, the result is the low 32 bits of the accumulator (modular wrap).
- R7: The overflow flag goes to 1 whenever a saturating narrow clamps. It stays at 1 until a clear, and wrap-mode narrowing never sets it.
- R8: Operands and controls applied before rising edge t are visible on the result and flag after rising edge t+2. The saturate input travels with its operation, and the result is refreshed on every cycle.
- R9: Intermediate sums beyond the 32-bit range lose no precision: a sum that returns into range reads exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand pair is valid this cycle |
| in_a | input | 32 | Signed operand A |
| in_b | input | 32 | Signed operand B |
| in_clr | input | 1 | Start a new sum |
| in_acc | input | 1 | Accumulate enable |
| in_sat | input | 1 | 1 selects saturating narrow, 0 selects wrap |
| res_q | output | 32 | Registered narrowed result |
| ovf_q | output | 1 | Sticky saturation flag |

## Verification
A behavioural model holds the pipeline as a queue and the accumulator as an 80-bit number, and the result is compared against it every cycle. Small mixed-sign products show that the multiply is signed and that the additions are correct. Full-scale positive and negative products push the sum out of range in both modes, which separates clamping from wrap and shows that the flag stays set. An overshoot-and-return sequence shows that the guard bits keep precision, and a lone operation timed against the clock pins down the two-stage latency. A long run with random controls then mixes clears, idle cycles and mode changes.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  typedef struct packed {
    logic vld;
    logic clr;
    logic en;
    logic sat;
  } mac_ctl_t;
endpackage

// File: rtl/mac_mult_pipe.sv
module mac_mult_pipe
  import sat_mac_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  input  mac_ctl_t          ctl_i,
  output logic [2*OP_W-1:0] prod_o,
  output mac_ctl_t          ctl_o
);
  localparam int P_W = 2 * OP_W;

  logic [OP_W-1:0] a_q, b_q;
  mac_ctl_t        s1_ctl_q, s2_ctl_q;
  logic [P_W-1:0]  prod_d, prod_q;
  logic            op_load, prod_load;

  assign op_load   = ctl_i.vld;
  assign prod_load = s1_ctl_q.vld;

  always_comb begin
    prod_d = $signed({{OP_W{a_q[OP_W-1]}}, a_q}) * $signed({{OP_W{b_q[OP_W-1]}}, b_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (op_load) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (prod_load) begin
      prod_q <= prod_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ctl_q <= '0;
      s2_ctl_q <= '0;
    end else begin
      s1_ctl_q <= ctl_i;
      s2_ctl_q <= s1_ctl_q;
    end
  end

  assign prod_o = prod_q;
  assign ctl_o  = s2_ctl_q;

  AST_PROD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o.vld == $past(ctl_i.vld, 2)); // R8

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import sat_mac_pkg::*;
#(
  parameter int P_W   = 64,
  parameter int ACC_W = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [P_W-1:0]   prod_i,
  input  mac_ctl_t         ctl_i,
  output logic [ACC_W-1:0] acc_d_o,
  output logic [ACC_W-1:0] acc_q_o
);
  localparam int GUARD_W = ACC_W - P_W;

  logic [ACC_W-1:0] prod_ext, acc_d, acc_q;

  assign prod_ext = {{GUARD_W{prod_i[P_W-1]}}, prod_i};

  always_comb begin
    acc_d = acc_q;
    if (ctl_i.clr) begin
      acc_d = ctl_i.vld ? prod_ext : '0;
    end else if (ctl_i.en && ctl_i.vld) begin
      acc_d = acc_q + prod_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign acc_d_o = acc_d;
  assign acc_q_o = acc_q;

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.clr && !ctl_i.vld) |=> (acc_q == '0)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_i.clr && !(ctl_i.en && ctl_i.vld)) |=> $stable(acc_q)); // R3

endmodule

// File: rtl/mac_narrow.sv
module mac_narrow #(
  parameter int ACC_W = 80,
  parameter int OUT_W = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             sat_i,
  output logic [OUT_W-1:0] out_o,
  output logic             clamp_o
);
  localparam int TOP_W = ACC_W - OUT_W + 1;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [TOP_W-1:0] top_bits;
  logic             fits;

  assign top_bits = acc_i[ACC_W-1:OUT_W-1];
  assign fits     = (&top_bits) | ~(|top_bits);

  always_comb begin
    clamp_o = sat_i & ~fits;
    if (clamp_o) begin
      out_o = acc_i[ACC_W-1] ? NEG_MIN : POS_MAX;
    end else begin
      out_o = acc_i[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/sat_mac.sv
module sat_mac
  import sat_mac_pkg::*;
#(
  parameter int OP_W  = 32,
  parameter int ACC_W = 80,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [OP_W-1:0]  in_a,
  input  logic [OP_W-1:0]  in_b,
  input  logic             in_clr,
  input  logic             in_acc,
  input  logic             in_sat,
  output logic [OUT_W-1:0] res_q,
  output logic             ovf_q
);
  localparam int P_W = 2 * OP_W;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  mac_ctl_t         in_ctl, acc_ctl;
  logic [P_W-1:0]   prod;
  logic [ACC_W-1:0] acc_d, acc_q;
  logic [OUT_W-1:0] res_d, narrow_out;
  logic             ovf_d, clamp;

  assign in_ctl = '{vld: in_vld, clr: in_clr, en: in_acc, sat: in_sat};

  mac_mult_pipe #(.OP_W(OP_W)) i_mult (
    .clk(clk), .rst_n(rst_n), .a_i(in_a), .b_i(in_b),
    .ctl_i(in_ctl), .prod_o(prod), .ctl_o(acc_ctl)
  );

  mac_accum #(.P_W(P_W), .ACC_W(ACC_W)) i_accum (
    .clk(clk), .rst_n(rst_n), .prod_i(prod), .ctl_i(acc_ctl),
    .acc_d_o(acc_d), .acc_q_o(acc_q)
  );

  mac_narrow #(.ACC_W(ACC_W), .OUT_W(OUT_W)) i_narrow (
    .acc_i(acc_d), .sat_i(acc_ctl.sat), .out_o(narrow_out), .clamp_o(clamp)
  );

  always_comb begin
    res_d = narrow_out;
    ovf_d = (acc_ctl.clr ? 1'b0 : ovf_q) | clamp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      res_q <= res_d;
      ovf_q <= ovf_d;
    end
  end

  AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (res_q == POS_MAX || res_q == NEG_MIN)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !acc_ctl.clr) |=> ovf_q); // R7

  AST_WRAP_CLEAR_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ctl.clr && !acc_ctl.sat) |=> !ovf_q); // R4

  AST_RESULT_TRACKS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ctl.sat |=> (res_q == acc_q[OUT_W-1:0])); // R6

endmodule

// File: tb/test_sat_mac.sv
module test_sat_mac;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld, in_clr, in_acc, in_sat;
  logic [31:0] in_a, in_b;
  logic [31:0] res_q;
  logic        ovf_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sat_mac i_sat_mac (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
    .in_clr(in_clr), .in_acc(in_acc), .in_sat(in_sat),
    .res_q(res_q), .ovf_q(ovf_q)
  );

  typedef struct {
    bit v; bit c; bit e; bit s;
    logic signed [31:0] a;
    logic signed [31:0] b;
  } op_t;

  op_t                q[$];
  logic signed [79:0] macc;
  logic [31:0]        e_res;
  bit                 e_ovf;
  string              e_tag;

  // Behavioural reference: operations wait two edges in a queue, then act.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      macc  = '0;
      e_res = '0;
      e_ovf = 1'b0;
      e_tag = "R1";
    end else begin
      op_t o;
      o.v = in_vld; o.c = in_clr; o.e = in_acc; o.s = in_sat;
      o.a = in_a;   o.b = in_b;
      q.push_back(o);
      if (q.size() > 2) begin
        op_t x;
        longint p;
        bit clamp;
        x = q.pop_front();
        p = longint'(x.a) * longint'(x.b);
        if (x.c) begin
          macc  = x.v ? 80'(p) : '0;
          e_tag = "R4";
        end else if (x.v && x.e) begin
          macc  = macc + 80'(p);
          e_tag = "R2";
        end else begin
          e_tag = "R3";
        end
        clamp = 1'b0;
        if (x.s && macc > 80'sd2147483647) begin
          e_res = 32'h7FFF_FFFF; clamp = 1'b1; e_tag = "R5";
        end else if (x.s && macc < -80'sd2147483648) begin
          e_res = 32'h8000_0000; clamp = 1'b1; e_tag = "R5";
        end else begin
          e_res = macc[31:0];
          if (!x.s && (macc > 80'sd2147483647 || macc < -80'sd2147483648)) e_tag = "R6";
        end
        e_ovf = (x.c ? 1'b0 : e_ovf) | clamp;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare with the model on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(e_tag, res_q, e_res);
      chk("R7", {31'b0, ovf_q}, {31'b0, e_ovf});
    end
  end

  task automatic drv(input bit v, input logic [31:0] a, input logic [31:0] b,
                     input bit c, input bit e, input bit s);
    in_vld = v; in_a = a; in_b = b; in_clr = c; in_acc = e; in_sat = s;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit s);
    for (int i = 0; i < n; i++) drv(1'b0, '0, '0, 1'b0, 1'b0, s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_vld = 0; in_a = '0; in_b = '0; in_clr = 0; in_acc = 0; in_sat = 0;
    repeat (3) @(negedge clk);
    chk("R1", res_q, 32'h0);
    chk("R1", {31'b0, ovf_q}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", res_q, 32'h0);

    // R8 latency: visible only after the second rising edge.
    drv(1, 32'd5, 32'd7, 1, 0, 0);
    chk("R8", res_q, 32'h0);
    idle(1, 0);
    chk("R8", res_q, 32'h0);
    idle(1, 0);
    chk("R8", res_q, 32'd35);

    // R2 signed accumulation with mixed signs
    drv(1, 32'd3, 32'd4, 1, 1, 0);
    drv(1, -32'sd6, 32'd9, 0, 1, 0);
    drv(1, -32'sd2, -32'sd8, 0, 1, 0);
    // R3 idle and not-enabled cycles hold
    drv(0, 32'd100, 32'd100, 0, 1, 0);
    drv(1, 32'd100, 32'd100, 0, 0, 0);
    idle(2, 0);
    chk("R2", res_q, 32'd3*32'd4 - 32'd54 + 32'd16);

    // R5 positive clamp, R7 sticky
    drv(1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 1, 1);
    drv(1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, 1);
    drv(1, -32'sd1, 32'h7FFF_FFFF, 0, 1, 1);
    idle(2, 1);
    chk("R5", res_q, 32'h7FFF_FFFF);
    chk("R7", {31'b0, ovf_q}, 32'h1);

    // R9 overshoot and return: two big adds undone, plus 5
    drv(1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 1, 0);
    drv(1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, 0);
    drv(1, 32'h8000_0001, 32'h7FFF_FFFF, 0, 1, 0);
    drv(1, 32'h8000_0001, 32'h7FFF_FFFF, 0, 1, 0);
    drv(1, 32'd5, 32'd1, 0, 1, 0);
    idle(2, 0);
    chk("R9", res_q, 32'd5);
    chk("R7", {31'b0, ovf_q}, 32'h0);

    // R6 wrap of an out-of-range sum
    drv(1, 32'h0001_0000, 32'h0001_0003, 1, 1, 0);
    idle(2, 0);
    chk("R6", res_q, 32'h0003_0000);
    chk("R7", {31'b0, ovf_q}, 32'h0);

    // R5 negative clamp, then R4 empty clear drops flag
    drv(1, 32'h8000_0000, 32'h7FFF_FFFF, 1, 1, 1);
    idle(2, 1);
    chk("R5", res_q, 32'h8000_0000);
    chk("R7", {31'b0, ovf_q}, 32'h1);
    drv(0, 32'd9, 32'd9, 1, 1, 1);
    idle(2, 1);
    chk("R4", res_q, 32'h0);
    chk("R4", {31'b0, ovf_q}, 32'h0);

    // Random mix against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if ($urandom_range(0, 2) == 0) begin
        ra = 32'($signed(ra) >>> 16);
        rb = 32'($signed(rb) >>> 12);
      end
      drv($urandom_range(0, 3) != 0, ra, rb, $urandom_range(0, 15) == 0,
          $urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)));
    end
    idle(4, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule